// File: doc/BRIEF.md
# GPIO Pin Function and Output Register Core

This block is the register core of a general-purpose I/O controller for 54 pins. A 32-bit register port, carried as a valid/ready request stream and a valid/ready response stream, reaches three kinds of state. The first is a 3-bit function code per pin that makes the pin an input, a GPIO output or one of six alternate functions. The second is a per-pin output latch that changes only through write-one-to-set and write-one-to-clear words, so software never needs a read-modify-write to drive a pin. The third is a pair of read-only level words that return the synchronized pin inputs.

Toward the pad ring the block drives the latch value, an output enable per pin and the function code of every pin. The alternate peripherals use the codes to take the pads over. Pins are split into two 32-bit banks: pin p sits in bank p/32 at bit p%32. Function codes are packed ten pins to a word.

A request is taken on a clock edge where `req_valid` and `req_ready` are both high. It yields exactly one response in the next cycle. That response carries read data, or zero for a write. Back-pressure comes only from the response side: `req_ready` is low while a response is waiting and `rsp_ready` is low. A stalled response holds its data unchanged.

Top module: `gpio_pinmux_core`

## Requirements
- R1: After reset every function code is 0, `pad_oe` and `pad_out` are all zero and `rsp_valid` is low.
- R2: The function code of pin p is written and read at byte offset (p/10)*4, word bits (p%10)*3+2 down to (p%10)*3. It also appears on `pin_fsel[p*3+2:p*3]`.
- R3: Code 0 means input, code 1 means GPIO output and codes 2 to 7 select alternate functions 0 to 5. `pad_oe[p]` is 1 exactly when pin p holds code 1.
- R4: A write to offset 0x1C (bank 0) or 0x20 (bank 1) sets the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R5: A write to offset 0x28 (bank 0) or 0x2C (bank 1) clears the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R6: A read of offset 0x34 (bank 0) or 0x38 (bank 1) returns `pad_in` through a two-flop synchronizer. A read taken on the second clock edge after an input change still returns the old level; a read taken later returns the new level. `pad_out` changes only on a clock edge that accepts a write.
- R7: `pad_out` always shows the output latch, whatever the pin's function. The latch keeps its value while the pin is not an output, so switching the pin to code 1 drives the pre-loaded level.
- R8: Unused bits read as zero and ignore writes. These are bits 30 and 31 of every function word, bits 12 to 31 of the function word at 0x14, and bits 22 to 31 of the bank-1 level word.
- R9: The set and clear words read as zero. Writes to the level words, to offsets outside the map, or to addresses with `req_addr[1:0]` not zero change nothing, and such reads return zero.
- R10: `req_ready` is high when no response is waiting or `rsp_ready` is high. Each accepted request produces one response in the next cycle, with data 0 for a write. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, zero for writes |
| pad_in | input | 54 | Asynchronous pin levels from the pads |
| pad_out | output | 54 | Output latch per pin |
| pad_oe | output | 54 | GPIO output enable per pin |
| pin_fsel | output | 162 | Function code per pin, 3 bits each |

## Verification
A level read can wait as a stalled response in the same cycles that the pin inputs move and a new register write is presented. The bench provokes this by holding `rsp_ready` low after a level read and then inverting `pad_in`. While the stall lasts, it offers a set write with all bits high. The response is judged correct if its data stays equal to the level sampled before the change, `req_ready` stays low and `pad_out` does not move until the stall ends.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int FSEL_W = 3;

  typedef enum logic [FSEL_W-1:0] {
    FN_IN   = 3'd0,
    FN_OUT  = 3'd1,
    FN_ALT0 = 3'd2,
    FN_ALT1 = 3'd3,
    FN_ALT2 = 3'd4,
    FN_ALT3 = 3'd5,
    FN_ALT4 = 3'd6,
    FN_ALT5 = 3'd7
  } pin_fn_e;

  // word indices (byte offset / 4) of each register group
  localparam int WORD_FSEL = 0;
  localparam int WORD_SET  = 7;
  localparam int WORD_CLR  = 10;
  localparam int WORD_LEV  = 13;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 54
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs #(
  parameter int NUM_PINS      = 54,
  parameter int PINS_PER_WORD = 10,
  parameter int FSEL_W        = 3,
  parameter int DATA_W        = 32,
  parameter int WORD_W        = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WORD_W-1:0]          wr_idx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [WORD_W-1:0]          rd_idx,
  output logic [DATA_W-1:0]          rd_word,
  output logic [NUM_PINS*FSEL_W-1:0] fsel_flat
);
  localparam int USED_W = PINS_PER_WORD * FSEL_W;

  logic [NUM_PINS*FSEL_W-1:0] fsel_q;
  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:USED_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_idx == WORD_W'(p / PINS_PER_WORD))
          fsel_q[p*FSEL_W +: FSEL_W] <= wdata[(p % PINS_PER_WORD)*FSEL_W +: FSEL_W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rd_idx == WORD_W'(p / PINS_PER_WORD))
        rd_word[(p % PINS_PER_WORD)*FSEL_W +: FSEL_W] = fsel_q[p*FSEL_W +: FSEL_W];
    end
  end

  assign fsel_flat = fsel_q;
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32,
  parameter int BANK_W   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [BANK_W-1:0]   bank,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] latch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bank == BANK_W'(p / DATA_W) && wdata[p % DATA_W]) begin
          if (set_en)
            latch[p] <= 1'b1;
          else if (clr_en)
            latch[p] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/gpio_pinmux_core.sv
module gpio_pinmux_core
  import gpio_pkg::*;
#(
  parameter int NUM_PINS      = 54,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int PINS_PER_WORD = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS*FSEL_W-1:0] pin_fsel
);
  localparam int WORD_W     = ADDR_W - 2;
  localparam int NUM_BANKS  = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int FSEL_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;

  logic              accept;
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              hit_fsel, hit_set, hit_clr, hit_lev;
  logic [WORD_W-1:0] set_off, clr_off, lev_off;
  logic [BANK_W-1:0] wr_bank;
  logic [DATA_W-1:0] fsel_rd, rd_mux;
  logic [NUM_PINS-1:0] level;
  logic [NUM_BANKS*DATA_W-1:0] level_ext;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign word      = req_addr[ADDR_W-1:2];

  assign set_off = word - WORD_W'(WORD_SET);
  assign clr_off = word - WORD_W'(WORD_CLR);
  assign lev_off = word - WORD_W'(WORD_LEV);

  assign hit_fsel = aligned && (word < WORD_W'(WORD_FSEL + FSEL_WORDS));
  assign hit_set  = aligned && (word >= WORD_W'(WORD_SET)) && (set_off < WORD_W'(NUM_BANKS));
  assign hit_clr  = aligned && (word >= WORD_W'(WORD_CLR)) && (clr_off < WORD_W'(NUM_BANKS));
  assign hit_lev  = aligned && (word >= WORD_W'(WORD_LEV)) && (lev_off < WORD_W'(NUM_BANKS));
  assign wr_bank  = hit_set ? set_off[BANK_W-1:0] : clr_off[BANK_W-1:0];

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (level)
  );

  gpio_fsel_regs #(
    .NUM_PINS      (NUM_PINS),
    .PINS_PER_WORD (PINS_PER_WORD),
    .FSEL_W        (FSEL_W),
    .DATA_W        (DATA_W),
    .WORD_W        (WORD_W)
  ) u_fsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept && req_write && hit_fsel),
    .wr_idx    (word),
    .wdata     (req_wdata),
    .rd_idx    (word),
    .rd_word   (fsel_rd),
    .fsel_flat (pin_fsel)
  );

  gpio_out_latch #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .BANK_W   (BANK_W)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (accept && req_write && hit_set),
    .clr_en (accept && req_write && hit_clr),
    .bank   (wr_bank),
    .wdata  (req_wdata),
    .latch  (pad_out)
  );

  // output driver is enabled only for the GPIO output code
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pad_oe[p] = (pin_fsel[p*FSEL_W +: FSEL_W] == FN_OUT);
  end

  always_comb begin
    level_ext = '0;
    level_ext[NUM_PINS-1:0] = level;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_fsel)
      rd_mux = fsel_rd;
    else if (hit_lev)
      rd_mux = level_ext[lev_off[BANK_W-1:0]*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk #(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [DATA_W-1:0]   req_wdata,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe
);
  logic unused_wd;
  assign unused_wd = ^req_wdata[DATA_W-1:1];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && !rsp_valid));

  // R4
  set_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == ADDR_W'(8'h1C) && req_wdata[0])
    |=> pad_out[0]);

  // R5
  clr_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == ADDR_W'(8'h28) && req_wdata[0])
    |=> !pad_out[0]);

  // R6
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(pad_out));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

bind gpio_pinmux_core gpio_pinmux_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/sim_gpio_pinmux_core.sv
`timescale 1ns/1ps
module sim_gpio_pinmux_core;
  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP*3-1:0] pin_fsel;

  int vectors = 0;
  int fails = 0;
  logic [NP*3-1:0] m_fsel = '0;
  logic [NP-1:0]   m_out = '0;
  logic [31:0]     seed = 32'h1234_5678;
  logic [31:0]     rd;

  always #2 clk = ~clk;

  gpio_pinmux_core u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_fsel(pin_fsel)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] fsel_word(input int w);
    logic [31:0] r = '0;
    for (int p = w*10; p < w*10 + 10 && p < NP; p++)
      r[(p%10)*3 +: 3] = m_fsel[p*3 +: 3];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = (m_fsel[p*3 +: 3] == 3'd1);
    return r;
  endfunction

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 response present", {255'd0, rsp_valid}, 256'd1);
    q = rsp_rdata;
  endtask

  task automatic wr_fsel(input int w, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, 8'(w*4), d, q);
    for (int p = w*10; p < w*10 + 10 && p < NP; p++)
      m_fsel[p*3 +: 3] = d[(p%10)*3 +: 3];
    check("R10 write response zero", {224'd0, q}, 256'd0);
  endtask

  task automatic wr_set(input int b, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, 8'(8'h1C + b*4), d, q);
    for (int p = b*32; p < b*32 + 32 && p < NP; p++) if (d[p%32]) m_out[p] = 1'b1;
  endtask

  task automatic wr_clr(input int b, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, 8'(8'h28 + b*4), d, q);
    for (int p = b*32; p < b*32 + 32 && p < NP; p++) if (d[p%32]) m_out[p] = 1'b0;
  endtask

  function automatic logic [31:0] lev_exp(input int b, input logic [NP-1:0] v);
    logic [63:0] e = '0;
    e[NP-1:0] = v;
    return e[b*32 +: 32];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NP-1:0] old_in;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", {202'd0, pad_oe}, 256'd0);
    check("R1 pad_out", {202'd0, pad_out}, 256'd0);
    check("R1 pin_fsel", {94'd0, pin_fsel}, 256'd0);
    check("R1 rsp_valid", {255'd0, rsp_valid}, 256'd0);
    rst_n = 1'b1;
    for (int w = 0; w < 6; w++) begin
      bus(1'b0, 8'(w*4), 32'd0, rd);
      check("R1 fsel word", {224'd0, rd}, 256'd0);
    end

    // R2 R3 R8: every code on every pin, then random words with junk high bits
    for (int r = 0; r < 16; r++) begin
      for (int w = 0; w < 6; w++) begin
        logic [31:0] d;
        seed = next_rand(seed);
        if (r < 8) begin
          d = {2'b11, 30'd0};
          for (int k = 0; k < 10; k++) d[k*3 +: 3] = 3'((w*10 + k + r) % 8);
        end else d = seed;
        wr_fsel(w, d);
        check("R2 pin_fsel", {94'd0, pin_fsel}, {94'd0, m_fsel});
        check("R3 pad_oe", {202'd0, pad_oe}, {202'd0, exp_oe()});
        bus(1'b0, 8'(w*4), 32'd0, rd);
        check("R8 fsel readback", {224'd0, rd}, {224'd0, fsel_word(w)});
      end
    end

    // R4 R5 single-pin walk
    for (int p = 0; p < NP; p++) begin
      wr_set(p/32, 32'd1 << (p%32));
      check("R4 set pin", {202'd0, pad_out}, {202'd0, m_out});
    end
    for (int p = 0; p < NP; p += 3) begin
      wr_clr(p/32, 32'd1 << (p%32));
      check("R5 clr pin", {202'd0, pad_out}, {202'd0, m_out});
    end
    wr_set(0, 32'd0); wr_clr(1, 32'd0);
    check("R4 R5 zero data no effect", {202'd0, pad_out}, {202'd0, m_out});
    for (int i = 0; i < 20; i++) begin
      seed = next_rand(seed); wr_set(i%2, seed);
      check("R4 set pattern", {202'd0, pad_out}, {202'd0, m_out});
      seed = next_rand(seed); wr_clr((i/2)%2, seed);
      check("R5 clr pattern", {202'd0, pad_out}, {202'd0, m_out});
    end

    // R7 latch kept across modes
    for (int w = 0; w < 6; w++) wr_fsel(w, 32'd0);
    wr_clr(0, '1); wr_clr(1, '1);
    wr_set(0, 32'hA5A5_3C3C); wr_set(1, 32'h0015_5AA5);
    check("R7 input mode oe", {202'd0, pad_oe}, 256'd0);
    check("R7 latch preloaded", {202'd0, pad_out}, {202'd0, m_out});
    for (int w = 0; w < 6; w++) wr_fsel(w, 32'h0924_9249);
    check("R7 output mode oe", {202'd0, pad_oe}, {202'd0, {NP{1'b1}}});
    check("R7 drives preload", {202'd0, pad_out}, {202'd0, m_out});

    // R8 bank 1 upper set bits ignored
    wr_set(1, 32'hFFFF_FFFF);
    check("R8 bank1 set", {202'd0, pad_out}, {202'd0, m_out});

    // R6 level path with synchronizer latency
    for (int i = 0; i < 12; i++) begin
      old_in = pad_in;
      seed = next_rand(seed);
      @(negedge clk);
      pad_in = {seed[21:0], next_rand(seed)};
      bus(1'b0, 8'h34, 32'd0, rd);
      check("R6 early read old", {224'd0, rd}, {224'd0, lev_exp(0, old_in)});
      bus(1'b0, 8'h34, 32'd0, rd);
      check("R6 bank0 level", {224'd0, rd}, {224'd0, lev_exp(0, pad_in)});
      bus(1'b0, 8'h38, 32'd0, rd);
      check("R8 bank1 level", {224'd0, rd}, {224'd0, lev_exp(1, pad_in)});
    end

    // R9 ignored writes and zero reads
    bus(1'b1, 8'h34, 32'hFFFF_FFFF, rd);
    bus(1'b1, 8'h1D, 32'hFFFF_FFFF, rd);
    bus(1'b1, 8'h29, 32'hFFFF_FFFF, rd);
    bus(1'b1, 8'h40, 32'hFFFF_FFFF, rd);
    bus(1'b1, 8'h01, 32'h0000_0000, rd);
    check("R9 pad_out unchanged", {202'd0, pad_out}, {202'd0, m_out});
    check("R9 fsel unchanged", {94'd0, pin_fsel}, {94'd0, m_fsel});
    bus(1'b0, 8'h34, 32'd0, rd);
    check("R9 level not writable", {224'd0, rd}, {224'd0, lev_exp(0, pad_in)});
    bus(1'b0, 8'h1C, 32'd0, rd);
    check("R9 set reads zero", {224'd0, rd}, 256'd0);
    bus(1'b0, 8'h2C, 32'd0, rd);
    check("R9 clr reads zero", {224'd0, rd}, 256'd0);
    bus(1'b0, 8'h35, 32'd0, rd);
    check("R9 misaligned reads zero", {224'd0, rd}, 256'd0);
    bus(1'b0, 8'h18, 32'd0, rd);
    check("R9 hole reads zero", {224'd0, rd}, 256'd0);

    // R10 back-pressure while inputs change and a write waits
    wr_clr(0, '1);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h34;
    old_in = pad_in;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 stalled valid", {255'd0, rsp_valid}, 256'd1);
    check("R10 stalled data", {224'd0, rsp_rdata}, {224'd0, lev_exp(0, old_in)});
    pad_in = ~pad_in;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h1C; req_wdata = '1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 ready low", {255'd0, req_ready}, 256'd0);
      check("R10 data held", {224'd0, rsp_rdata}, {224'd0, lev_exp(0, old_in)});
      check("R10 write blocked", {202'd0, pad_out}, {202'd0, m_out});
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 response drained", {255'd0, rsp_valid}, 256'd0);
    check("R10 no late write", {202'd0, pad_out}, {202'd0, m_out});

    finish_run();
  end
endmodule